// File: doc/BRIEF.md
# Power-Rail Request Interrupt Registers

This block sits between a storage-card controller core and the host processor. The core raises short request pulses when it needs the card bus power switched off or on, or when it needs the signalling voltage of the I/O pads moved to its low or high level. Each request is caught in a sticky status bit. An interrupt line goes high while any caught request is enabled in a mask register. The processor services the interrupt by reading the status, clearing what it handled with a write-one-to-clear register, and doing the power or voltage work elsewhere. It then reports the outcome by writing success flags to a control register. Each success flag turns into a single-cycle acknowledge pulse back to the core.

The register port is a plain single-cycle write strobe with a combinational read path. Four word addresses are decoded. All four request kinds share the one interrupt line. The acknowledge path has two categories: bus power and I/O voltage.

Top module: `pwr_req_irq_regs`

## Requirements
- R1: After reset the status and mask registers read zero, `irq` is low, and both acknowledge outputs are low.
- R2: A request input that is high across a clock edge sets its status bit. The bit stays set after the input falls, until software clears it. The request bit order is: 0 bus power off, 1 bus power on, 2 I/O voltage low, 3 I/O voltage high.
- R3: A write to the clear register (offset 0xE4) clears every status bit whose write-data bit (bits 3..0) is 1 and leaves the others unchanged. The clear register reads as zero.
- R4: When a request and a clear of the same status bit happen in the same cycle, the bit ends up set.
- R5: The mask register (offset 0xE0) stores write-data bits 3..0 and reads them back. Its upper read bits are zero. A mask bit of 1 enables that source.
- R6: From the cycle after a status or mask update, `irq` is high exactly when at least one status bit and its mask bit are both 1.
- R7: The status register (offset 0xDC) reads the four status bits in bits 3..0, with zeros above. Writes to it have no effect.
- R8: A write to the control register (offset 0xE8) gives a one-cycle `bus_ack` pulse in the next cycle when write-data bit 0 is 1, and a one-cycle `io_ack` pulse when bit 2 is 1. Other bits produce nothing. The register reads as zero.
- R9: Reads from any other offset return zero, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| req_in | input | 4 | Request pulses: bus off, bus on, I/O low, I/O high |
| irq | output | 1 | Interrupt to the processor |
| bus_ack | output | 1 | Bus-power success pulse to the core |
| io_ack | output | 1 | I/O-voltage success pulse to the core |

## Verification
Two functions can fall on the same clock edge: a new request from the core, and software's write-one-to-clear of that same bit. The bench drives every request pattern together with every clear pattern in one cycle, starting once from an empty status and once from a full one. It judges each result against (old status AND NOT clear) OR request. Separately, every status pattern is swept against every mask pattern to check the interrupt. Every control-write pattern is swept to check the shape of the acknowledge pulses.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;
    localparam int NREQ        = 4;
    localparam int REQ_BUS_OFF = 0;
    localparam int REQ_BUS_ON  = 1;
    localparam int REQ_IO_LOW  = 2;
    localparam int REQ_IO_HIGH = 3;
    localparam int ACK_BUS_BIT = 0;
    localparam int ACK_IO_BIT  = 2;

    typedef logic [NREQ-1:0] req_vec_t;

    typedef struct packed {
        req_vec_t flags;
    } latch_st_t;

    typedef struct packed {
        logic bus_ok;
        logic io_ok;
    } ack_st_t;

    typedef struct packed {
        req_vec_t enable;
    } cfg_st_t;
endpackage

// File: rtl/pwr_req_latch.sv
module pwr_req_latch
    import pwr_req_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  req_vec_t req_i,
    input  req_vec_t clr_i,
    output req_vec_t status_o
);
    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREQ; i++) begin
            // a request in the same cycle overrides a clear
            if (req_i[i])
                st_d.flags[i] = 1'b1;
            else if (clr_i[i])
                st_d.flags[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign status_o = st_q.flags;

    assert_req_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flags & $past(req_i)) == $past(req_i)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flags & $past(st_q.flags & ~clr_i)) == $past(st_q.flags & ~clr_i)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flags & $past(clr_i & ~req_i)) == '0));
endmodule

// File: rtl/pwr_req_ack.sv
module pwr_req_ack
    import pwr_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic bus_ok_i,
    input  logic io_ok_i,
    output logic bus_ack_o,
    output logic io_ack_o
);
    ack_st_t ack_d, ack_q;

    always_comb begin
        // pulses last one cycle unless renewed by another write
        ack_d        = '0;
        ack_d.bus_ok = wr_i && bus_ok_i;
        ack_d.io_ok  = wr_i && io_ok_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ack_q <= '0;
        else
            ack_q <= ack_d;
    end

    assign bus_ack_o = ack_q.bus_ok;
    assign io_ack_o  = ack_q.io_ok;

    assert_bus_ack_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_o |-> $past(wr_i && bus_ok_i));

    assert_io_ack_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack_o |-> $past(wr_i && io_ok_i));
endmodule

// File: rtl/pwr_req_irq_regs.sv
module pwr_req_irq_regs
    import pwr_req_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 'hDC,
    parameter logic [ADDR_W-1:0] MASK_OFS   = 'hE0,
    parameter logic [ADDR_W-1:0] CLEAR_OFS  = 'hE4,
    parameter logic [ADDR_W-1:0] CTRL_OFS   = 'hE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NREQ-1:0]   req_in,
    output logic              irq,
    output logic              bus_ack,
    output logic              io_ack
);
    localparam int PAD_W = DATA_W - NREQ;

    cfg_st_t  cfg_d, cfg_q;
    req_vec_t status;
    req_vec_t clr_vec;
    logic     wr_mask, wr_clear, wr_ctrl;
    logic     wdata_unused;

    assign wr_mask      = reg_we && (reg_addr == MASK_OFS);
    assign wr_clear     = reg_we && (reg_addr == CLEAR_OFS);
    assign wr_ctrl      = reg_we && (reg_addr == CTRL_OFS);
    assign clr_vec      = wr_clear ? reg_wdata[NREQ-1:0] : '0;
    assign wdata_unused = ^reg_wdata[DATA_W-1:NREQ];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_mask)
            cfg_d.enable = reg_wdata[NREQ-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else
            cfg_q <= cfg_d;
    end

    pwr_req_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_in),
        .clr_i    (clr_vec),
        .status_o (status)
    );

    pwr_req_ack u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_ctrl),
        .bus_ok_i  (reg_wdata[ACK_BUS_BIT]),
        .io_ok_i   (reg_wdata[ACK_IO_BIT]),
        .bus_ack_o (bus_ack),
        .io_ack_o  (io_ack)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == STATUS_OFS)
            reg_rdata = {{PAD_W{1'b0}}, status};
        else if (reg_addr == MASK_OFS)
            reg_rdata = {{PAD_W{1'b0}}, cfg_q.enable};
    end

    assign irq = |(status & cfg_q.enable);

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (cfg_q.enable == $past(reg_wdata[NREQ-1:0])));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(cfg_q.enable));

    assert_irq_needs_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0 && cfg_q.enable != '0));

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NREQ] == '0);
endmodule

// File: tb/pwr_req_irq_regs_tb.sv
module pwr_req_irq_regs_tb;
    localparam logic [7:0] A_STAT = 8'hDC;
    localparam logic [7:0] A_MASK = 8'hE0;
    localparam logic [7:0] A_CLR  = 8'hE4;
    localparam logic [7:0] A_CTRL = 8'hE8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [3:0]  req_in = '0;
    logic        irq, bus_ack, io_ack;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_req_irq_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .req_in(req_in),
        .irq(irq), .bus_ack(bus_ack), .io_ack(io_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_req(input logic [3:0] v);
        @(negedge clk);
        req_in = v;
        @(negedge clk);
        req_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_STAT, d); chk("R1 status after reset", d, 0);
        rd(A_MASK, d); chk("R1 mask after reset", d, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 acks after reset", {bus_ack, io_ack}, 0);

        // R2 sticky capture, R5 mask readback, R6 irq for all status x mask
        for (int s = 0; s < 16; s++) begin
            wr(A_CLR, 32'hF);
            pulse_req(s[3:0]);
            rd(A_STAT, d); chk("R2 sticky status", d, s);
            for (int m = 0; m < 16; m++) begin
                wr(A_MASK, 32'hFFFF_FFF0 | m);
                chk($sformatf("R6 irq s=%0d m=%0d", s, m), irq, ((s & m) != 0));
                if (s == 0) begin
                    rd(A_MASK, d); chk("R5 mask readback", d, m);
                end
            end
            wr(A_MASK, 32'h0);
        end

        // R3 write-one-to-clear for all status x clear patterns
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                wr(A_CLR, 32'hF);
                pulse_req(s[3:0]);
                wr(A_CLR, c);
                rd(A_STAT, d);
                chk($sformatf("R3 clear s=%0d c=%0d", s, c), d, s & ~c & 4'hF);
            end
        end
        rd(A_CLR, d); chk("R3 clear reads zero", d, 0);

        // R4 request and clear in the same cycle
        for (int k = 0; k < 2; k++) begin
            for (int r = 0; r < 16; r++) begin
                for (int c = 0; c < 16; c++) begin
                    logic [3:0] s0;
                    s0 = (k == 0) ? 4'h0 : 4'hF;
                    wr(A_CLR, 32'hF);
                    pulse_req(s0);
                    @(negedge clk);
                    req_in = r[3:0]; reg_addr = A_CLR; reg_wdata = c; reg_we = 1'b1;
                    @(negedge clk);
                    req_in = '0; reg_we = 1'b0; reg_wdata = '0;
                    rd(A_STAT, d);
                    chk($sformatf("R4 same-cycle s0=%0h r=%0d c=%0d", s0, r, c), d,
                        ((s0 & ~c[3:0]) | r[3:0]));
                end
            end
        end

        // R7 status is read-only
        wr(A_CLR, 32'hF);
        pulse_req(4'h5);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R7 status write ignored", d, 32'h5);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); chk("R7 status write of zero ignored", d, 32'h5);

        // R8 acknowledge pulses for every control pattern
        for (int w = 0; w < 16; w++) begin
            wr(A_CTRL, 32'hA5A5_A5A0 | w);
            chk($sformatf("R8 bus_ack w=%0d", w), bus_ack, w[0]);
            chk($sformatf("R8 io_ack w=%0d", w), io_ack, w[2]);
            @(negedge clk);
            chk("R8 acks self-clear", {bus_ack, io_ack}, 0);
        end
        rd(A_CTRL, d); chk("R8 control reads zero", d, 0);

        // R9 unmapped offsets
        wr(A_MASK, 32'h9);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'hD8, 32'hFFFF_FFFF);
        wr(8'hEC, 32'hFFFF_FFFF);
        wr(8'hE1, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R9 status untouched", d, 32'h5);
        rd(A_MASK, d); chk("R9 mask untouched", d, 32'h9);
        chk("R9 no ack from unmapped write", {bus_ack, io_ack}, 0);
        rd(8'hEC, d); chk("R9 unmapped reads zero", d, 0);
        rd(8'h00, d); chk("R9 offset zero reads zero", d, 0);
        chk("R6 irq with s=5 m=9", irq, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule